// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked one-shot. It watches two trigger inputs. One of them fires on a falling edge and the other fires on a rising edge. Each trigger is qualified by the level of the other input. When a trigger qualifies, the block raises `pulse_o` for a number of clock cycles taken from `width_i`, and drives `pulse_no` as its complement.

A qualifying trigger that arrives during a pulse reloads the timer with the width present at that moment. A steady stream of triggers can therefore hold the output high with no gap. The active-low `clear_ni` input ends a pulse and blocks triggering for as long as it is low. Releasing it never starts a pulse.

All three functional inputs are treated as asynchronous. Each passes through a two-stage synchronizer before any edge is detected, which gives a fixed three-clock latency from an input change to the start of the pulse.

Top module: `oneshot_pulse`

## Requirements
- R1: A HIGH-to-LOW change on `fall_trig_i` while `rise_trig_i` is HIGH starts a pulse.
- R2: A LOW-to-HIGH change on `rise_trig_i` while `fall_trig_i` is LOW starts a pulse.
- R3: No other input change starts a pulse. This covers a falling `fall_trig_i` while `rise_trig_i` is LOW, a rising `rise_trig_i` while `fall_trig_i` is HIGH, a rising `fall_trig_i`, and a falling `rise_trig_i`.
- R4: With `clear_ni` HIGH, an input change applied before clock edge k makes `pulse_o` HIGH from edge k+2. It stays HIGH for exactly `width_i` cycles, counting the width sampled at the trigger.
- R5: A qualifying trigger during a pulse reloads the remaining length with the `width_i` value present at that trigger, whether that value is larger or smaller. Triggers spaced closer than the width keep `pulse_o` HIGH continuously.
- R6: A `width_i` of 0 produces a pulse of exactly one cycle.
- R7: `pulse_no` is always the complement of `pulse_o`.
- R8: When `clear_ni` goes LOW, `pulse_o` is LOW from the second clock edge after the change, even in the middle of a pulse.
- R9: While `clear_ni` is LOW, trigger edges are ignored. The release of `clear_ni` never starts a pulse, even when the inputs sit at levels that would qualify.
- R10: After `rst_ni` is released, `pulse_o` is LOW and no pulse appears unless a qualifying edge occurs after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| fall_trig_i | input | 1 | Trigger input that fires on a falling edge; also the gate for `rise_trig_i` when LOW |
| rise_trig_i | input | 1 | Trigger input that fires on a rising edge; also the gate for `fall_trig_i` when HIGH |
| clear_ni | input | 1 | Active-low pulse clear and trigger inhibit (asynchronous, synchronized inside) |
| width_i | input | WIDTH_W | Pulse length in clock cycles, sampled at each trigger |
| pulse_o | output | 1 | One-shot output, HIGH during a pulse |
| pulse_no | output | 1 | Complement of `pulse_o` |

## Verification
The bench moves each trigger input through every non-qualifying transition. A design that fired on levels, or ignored the gating input, would show a pulse there. Retriggering is checked with a shorter width sampled at the second trigger, which exposes a design that keeps the old count or adds the widths. It is also checked with a dense trigger train that must leave no LOW gap. The clear input is dropped mid-pulse, and it is released with qualifying levels already present at the trigger inputs. A design that fires on the release edge, or that lets edges taken while cleared leak through, would produce a pulse after the release. A zero width is also applied, where a design without the floor to one cycle would emit nothing.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // synchronized input levels, in the order the synchronizer vector carries them
  typedef struct packed {
    logic fall_in;
    logic rise_in;
    logic clr_n;
  } lvl_t;

  localparam int unsigned NUM_IN = 3;

  // reset levels chosen so that the first real sample cannot look like a trigger:
  // fall input starts LOW (cannot fall), rise input starts HIGH (cannot rise),
  // clear starts asserted so triggering is blocked until it is synchronized
  localparam logic [NUM_IN-1:0] SYNC_RST = 3'b010;

  function automatic logic [31:0] floor_one(input logic [31:0] w);
    return (w == 32'd0) ? 32'd1 : w;
  endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned         N      = 3,
  parameter int unsigned         STAGES = 2,
  parameter logic [N-1:0]        RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end

    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig
  import oneshot_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_t lvl_i,
  output logic fire_o
);

  lvl_t prev_q;

  // edge history keeps running while cleared, so edges seen then are consumed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= lvl_t'(SYNC_RST);
    else         prev_q <= lvl_i;
  end

  logic fall_edge, rise_edge;
  assign fall_edge = prev_q.fall_in & ~lvl_i.fall_in;
  assign rise_edge = ~prev_q.rise_in & lvl_i.rise_in;

  assign fire_o = lvl_i.clr_n &
                  ((fall_edge & lvl_i.rise_in) | (rise_edge & ~lvl_i.fall_in));

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               clr_ni,
  input  logic [WIDTH_W-1:0] width_i,
  output logic [WIDTH_W-1:0] cnt_o,
  output logic               busy_o
);

  logic [WIDTH_W-1:0] cnt_q, cnt_d, load_val;

  assign load_val = (width_i == '0) ? WIDTH_W'(1) : width_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!clr_ni)            cnt_d = '0;
    else if (fire_i)        cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - WIDTH_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fall_trig_i,
  input  logic               rise_trig_i,
  input  logic               clear_ni,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_o,
  output logic               pulse_no
);

  logic [NUM_IN-1:0]  raw_in, sync_out;
  lvl_t               lvl_s;
  logic               clr_s, fire_w, busy_w;
  logic [WIDTH_W-1:0] cnt_w;

  assign raw_in = {fall_trig_i, rise_trig_i, clear_ni};

  oneshot_sync #(
    .N      (NUM_IN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign lvl_s = lvl_t'(sync_out);
  assign clr_s = lvl_s.clr_n;

  oneshot_trig u_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_s),
    .fire_o(fire_w)
  );

  oneshot_timer #(.WIDTH_W(WIDTH_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire_w),
    .clr_ni (clr_s),
    .width_i(width_i),
    .cnt_o  (cnt_w),
    .busy_o (busy_w)
  );

  // clear gates the output one cycle ahead of the counter being zeroed
  assign pulse_o  = busy_w & clr_s;
  assign pulse_no = (cnt_w == '0) | ~clr_s;

endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
  parameter int unsigned WIDTH_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clear_ni,
  input logic [WIDTH_W-1:0] width_i,
  input logic               pulse_o,
  input logic               pulse_no,
  input logic               fire,
  input logic               clr_s,
  input logic [WIDTH_W-1:0] cnt
);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  a_r7_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_no == ~pulse_o);

  a_r3_rise_needs_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0) && pulse_o && !$past(pulse_o) |-> $past(fire));

  a_r4_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_s && !fire && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

  a_r6_zero_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && width_i == '0 |=> cnt == 1);

  a_r8_clear_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) && !clear_ni && !$past(clear_ni) && !$past(clear_ni, 2) |-> !pulse_o);

  a_r9_no_fire_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_s |-> !fire);

endmodule

bind oneshot_pulse oneshot_pulse_chk #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clear_ni(clear_ni),
  .width_i (width_i),
  .pulse_o (pulse_o),
  .pulse_no(pulse_no),
  .fire    (fire_w),
  .clr_s   (clr_s),
  .cnt     (cnt_w)
);

// File: tb/oneshot_pulse_test.sv
`timescale 1ns/1ps
module oneshot_pulse_test;

  localparam int unsigned WW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a = 1'b1, b = 1'b1, clr_n = 1'b1;
  logic [WW-1:0] width = 8'd5;
  logic          q, qn;

  int n_chk = 0, n_bad = 0, compl_bad = 0;

  always #2.5 clk = ~clk;

  oneshot_pulse #(.WIDTH_W(WW)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .fall_trig_i(a),
    .rise_trig_i(b),
    .clear_ni   (clr_n),
    .width_i    (width),
    .pulse_o    (q),
    .pulse_no   (qn)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sample(output bit hi);
    @(negedge clk);
    if (qn !== ~q) compl_bad++;
    hi = (q === 1'b1);
  endtask

  task automatic watch(input int span, output int first, output int cnt);
    bit hi;
    first = -1; cnt = 0;
    for (int i = 1; i <= span; i++) begin
      sample(hi);
      if (hi) begin cnt++; if (first < 0) first = i; end
    end
  endtask

  task automatic idle();
    int f, c;
    a = 1'b1; b = 1'b0;
    watch(30, f, c);
  endtask

  task automatic t_reset();
    int f, c;
    chk(q === 1'b0, "R10", "pulse_o after reset", int'(q), 0);
    chk(qn === 1'b1, "R7", "pulse_no after reset", int'(qn), 1);
    watch(10, f, c);
    chk(c == 0, "R10", "spurious high cycles after reset", c, 0);
  endtask

  task automatic t_fall_trig();
    int f, c;
    idle();
    b = 1'b1; watch(4, f, c);
    width = 8'd5; a = 1'b0;
    watch(12, f, c);
    chk(f == 3, "R4", "fall trigger start offset", f, 3);
    chk(c == 5, "R1", "fall trigger pulse length", c, 5);
  endtask

  task automatic t_rise_trig();
    int f, c;
    idle();
    a = 1'b0; watch(4, f, c);
    width = 8'd3; b = 1'b1;
    watch(10, f, c);
    chk(f == 3, "R4", "rise trigger start offset", f, 3);
    chk(c == 3, "R2", "rise trigger pulse length", c, 3);
  endtask

  task automatic t_non_qualifying();
    int f, c, tot;
    tot = 0;
    idle();
    width = 8'd4;
    a = 1'b0; watch(8, f, c); tot += c;  // fall with rise input LOW
    a = 1'b1; watch(8, f, c); tot += c;  // rise on fall input
    b = 1'b1; watch(8, f, c); tot += c;  // rise with fall input HIGH
    b = 1'b0; watch(8, f, c); tot += c;  // fall on rise input
    chk(tot == 0, "R3", "high cycles from non-qualifying edges", tot, 0);
  endtask

  task automatic t_retrigger_shorter();
    int first, cnt, at8;
    bit hi;
    idle();
    a = 1'b0; watch(4, first, cnt);
    width = 8'd6; b = 1'b1;
    first = -1; cnt = 0; at8 = 0;
    for (int i = 1; i <= 16; i++) begin
      sample(hi);
      if (hi) begin cnt++; if (first < 0) first = i; end
      if (i == 8) at8 = int'(hi);
      if (i == 4) b = 1'b0;
      if (i == 5) begin b = 1'b1; width = 8'd2; end
    end
    chk(first == 3, "R5", "retrigger first high", first, 3);
    chk(at8 == 1, "R5", "high at reload cycle", at8, 1);
    chk(cnt == 7, "R5", "length after shorter reload", cnt, 7);
  endtask

  task automatic t_full_duty();
    int first, cnt;
    bit hi;
    idle();
    a = 1'b0; watch(4, first, cnt);
    width = 8'd5;
    first = -1; cnt = 0;
    b = 1'b1;
    for (int i = 1; i <= 50; i++) begin
      sample(hi);
      if (hi) begin cnt++; if (first < 0) first = i; end
      if (i < 40) b = ((i % 4) < 2);
      else        b = 1'b0;
    end
    chk(first == 3, "R5", "train first high", first, 3);
    chk(cnt == 41, "R5", "gapless high cycles under trigger train", cnt, 41);
  endtask

  task automatic t_zero_width();
    int f, c;
    idle();
    b = 1'b1; watch(4, f, c);
    width = 8'd0; a = 1'b0;
    watch(8, f, c);
    chk(f == 3, "R6", "zero width start", f, 3);
    chk(c == 1, "R6", "zero width length", c, 1);
  endtask

  task automatic t_clear();
    int first, cnt, at8;
    bit hi;
    idle();
    a = 1'b0; watch(4, first, cnt);
    width = 8'd20; b = 1'b1;
    first = -1; cnt = 0; at8 = 0;
    for (int i = 1; i <= 12; i++) begin
      sample(hi);
      if (hi) begin cnt++; if (first < 0) first = i; end
      if (i == 8) at8 = int'(hi);
      if (i == 6) clr_n = 1'b0;
    end
    chk(at8 == 0, "R8", "pulse_o two edges after clear", at8, 0);
    chk(cnt == 5, "R8", "cycles before clear cut", cnt, 5);
    chk(qn === 1'b1, "R8", "pulse_no while cleared", int'(qn), 1);
    // edges during clear
    b = 1'b0; watch(4, first, cnt);
    a = 1'b1; watch(4, first, cnt);
    b = 1'b1; watch(4, first, cnt);
    width = 8'd4; a = 1'b0;
    watch(8, first, cnt);
    chk(cnt == 0, "R9", "pulse from edge while cleared", cnt, 0);
    // release with qualifying levels present
    clr_n = 1'b1;
    watch(10, first, cnt);
    chk(cnt == 0, "R9", "pulse on clear release", cnt, 0);
    // normal operation resumes
    b = 1'b0; watch(4, first, cnt);
    width = 8'd4; b = 1'b1;
    watch(10, first, cnt);
    chk(cnt == 4, "R9", "trigger after release", cnt, 4);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    a = 1'b1; b = 1'b1; clr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fall_trig();
    t_rise_trig();
    t_non_qualifying();
    t_retrigger_shorter();
    t_full_duty();
    t_zero_width();
    t_clear();
    chk(compl_bad == 0, "R7", "samples where pulse_no was not the complement", compl_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule